// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O controller built from a parameterised number of banks, each handling up to 32 pads. Every bank has its own register set that controls the pad drivers: a driven value, a per-pin direction and a per-pin open-drain mode. The pad tri-state controls come straight out of the block, and the pad inputs come straight in.

Each pin can also be turned into an interrupt source. Three per-bank configuration words pick the trigger for each pin: rising edge, falling edge, either edge, active-high level or active-low level. Detected events set sticky status bits that software clears by writing ones. Status ANDed with a per-pin enable gives the pending set of a bank, and the pending sets of all banks are ORed into one interrupt line.

The bus side is a plain single-cycle port. A write takes effect at the clock edge on which it is presented. Read data is combinational from the word address.

Top module: `banked_gpio`

## Requirements
- R1: Bank n occupies word indices n*8 to n*8+7 (byte offset = word index * 4). Within a bank the word index selects: 0 open-drain enable, 1 data, 2 direction, 3 trigger polarity, 4 both-edge select, 5 interrupt enable, 6 level select, 7 status. Writable registers read back what was written, limited to the bank's width.
- R2: After reset every register reads zero, except direction, which reads all ones over the bank's width. pad_oe and irq are 0.
- R3: A direction bit of 0 makes the pin an output. When its open-drain bit is 0, the pin drives pad_oe=1 and pad_out equal to its data bit. A direction bit of 1 never drives the pad.
- R4: With the open-drain bit set on an output pin, a data bit of 1 releases the pad (pad_oe=0), and a data bit of 0 drives it low (pad_oe=1, pad_out=0).
- R5: Reading the data word returns the driven value for output pins. For input pins it returns the pad value after a two-flop synchronizer: it changes after the second rising clock edge following the pad change.
- R6: With level=0, both=0 and polarity=1, a rising synchronized pin sets its status bit. A falling one does not.
- R7: With level=0, both=0 and polarity=0, a falling synchronized pin sets its status bit. A rising one does not.
- R8: With level=0 and both=1, either edge sets the status bit, whatever the polarity bit holds.
- R9: With level=1, the pin is level-sensitive: active high when polarity=0, active low when polarity=1. While the active level is present, the status bit cannot be left clear; a clearing write does not remove it.
- R10: Status is sticky. Writing 1 to a status bit clears it, unless a trigger hits in the same cycle, in which case the trigger wins. Writing 0 leaves the bit unchanged.
- R11: irq is the OR, over all banks, of status AND interrupt enable. A disabled status bit stays readable, and it raises irq once enabled.
- R12: Bits at or above a bank's width read 0, never drive pad_oe, and never set status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | BSEL_W+3 | Word index (bank in upper bits, register in lower 3) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word (combinational) |
| pad_in | input | NBANK*32 | Pad input values, 32 per bank |
| pad_out | output | NBANK*32 | Pad output values |
| pad_oe | output | NBANK*32 | Pad output enables |
| irq | output | 1 | Shared interrupt request |

## Verification
A corrupted status or configuration bit appears at the ports within one cycle: irq follows the enabled status with no delay, and a status read shows the same bit. A wrong synchronizer or previous-value stage shows up as a status bit set by the wrong edge, or never set, three clock edges after the pad change. Drive faults show up on pad_oe and pad_out in the cycle after the register write. The bench therefore checks each trigger type in both directions, and reads status and irq before and after each clearing write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned WORD_W    = 32;
   localparam int unsigned REG_SEL_W = 3;

   typedef enum logic [REG_SEL_W-1:0] {
      RS_OPEN_DRAIN = 3'd0,
      RS_DATA       = 3'd1,
      RS_DIR        = 3'd2,
      RS_POL        = 3'd3,
      RS_BOTH       = 3'd4,
      RS_IRQ_EN     = 3'd5,
      RS_LEVEL      = 3'd6,
      RS_STATUS     = 3'd7
   } reg_sel_e;

   function automatic logic [WORD_W-1:0] width_mask(input int pins);
      logic [WORD_W-1:0] m;
      for (int i = 0; i < WORD_W; i++) m[i] = (i < pins);
      return m;
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         q      <= '0;
      end else begin
         meta_q <= d;
         q      <= meta_q;
      end
   end
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
   parameter int W = 32
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] prev,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] both,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] hit
);
   logic [W-1:0] rise, fall, edge_hit, level_hit;

   always_comb begin
      rise      = cur & ~prev;
      fall      = ~cur & prev;
      edge_hit  = (both & (rise | fall)) | (~both & ((pol & rise) | (~pol & fall)));
      level_hit = cur ^ pol;
      hit       = (lvl & level_hit) | (~lvl & edge_hit);
   end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int PINS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_SEL_W-1:0] reg_sel,
   input  logic [WORD_W-1:0]    wdata,
   output logic [WORD_W-1:0]    rdata,
   input  logic [WORD_W-1:0]    pad_in,
   output logic [WORD_W-1:0]    pad_out,
   output logic [WORD_W-1:0]    pad_oe,
   output logic                 pend_any
);
   localparam logic [WORD_W-1:0] VALID = width_mask(PINS);

   generate
      if (PINS < 1 || PINS > 32) begin : g_bad_pins
         $error("gpio_bank: PINS must be within 1..32");
      end
   endgenerate

   logic [WORD_W-1:0] od_q, out_q, dir_q, pol_q, both_q, en_q, lvl_q, stat_q;
   logic [WORD_W-1:0] cur, prev_q, hit, clr, wmask;

   gpio_sync #(.W(WORD_W)) u_sync (.clk(clk), .rst_n(rst_n), .d(pad_in), .q(cur));

   gpio_trig #(.W(WORD_W)) u_trig (
      .cur(cur), .prev(prev_q), .pol(pol_q), .both(both_q), .lvl(lvl_q), .hit(hit)
   );

   assign wmask = wdata & VALID;
   assign clr   = (wr_en && reg_sel == RS_STATUS) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         od_q   <= '0;
         out_q  <= '0;
         dir_q  <= VALID;
         pol_q  <= '0;
         both_q <= '0;
         en_q   <= '0;
         lvl_q  <= '0;
         stat_q <= '0;
         prev_q <= '0;
      end else begin
         prev_q <= cur;
         stat_q <= ((stat_q & ~clr) | hit) & VALID;
         if (wr_en) begin
            case (reg_sel_e'(reg_sel))
               RS_OPEN_DRAIN: od_q   <= wmask;
               RS_DATA:       out_q  <= wmask;
               RS_DIR:        dir_q  <= wmask;
               RS_POL:        pol_q  <= wmask;
               RS_BOTH:       both_q <= wmask;
               RS_IRQ_EN:     en_q   <= wmask;
               RS_LEVEL:      lvl_q  <= wmask;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_sel_e'(reg_sel))
         RS_OPEN_DRAIN: rdata = od_q;
         RS_DATA:       rdata = ((dir_q & cur) | (~dir_q & out_q)) & VALID;
         RS_DIR:        rdata = dir_q;
         RS_POL:        rdata = pol_q;
         RS_BOTH:       rdata = both_q;
         RS_IRQ_EN:     rdata = en_q;
         RS_LEVEL:      rdata = lvl_q;
         default:       rdata = stat_q;
      endcase
   end

   assign pad_oe   = ~dir_q & ~(od_q & out_q) & VALID;
   assign pad_out  = out_q & ~od_q & VALID;
   assign pend_any = |(stat_q & en_q);

   // R10: a one written to status clears the bit unless a trigger hit it in that cycle
   assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_sel == RS_STATUS) |=> ((stat_q & $past(wdata & ~hit)) == '0));
   // R10: status bits never drop without a clearing write
   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(stat_q & ~clr) & ~stat_q) == '0));
   // R9: a trigger hit on a valid pin always leaves its status bit set
   assert_hit_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(hit & VALID) & ~stat_q) == '0));
   // R3: a pin configured as input never drives its pad
   assert_input_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe & dir_q) == '0);
   // R12: bits above the width neither drive nor hold status
   assert_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | stat_q | pad_out) & ~VALID) == '0);
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
   import gpio_bank_pkg::*;
#(
   parameter  int NBANK          = 2,
   parameter  int PINS_PER_BANK  = 32,
   parameter  int LAST_BANK_PINS = 20,
   localparam int BSEL_W         = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int WA_W           = BSEL_W + REG_SEL_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_wr,
   input  logic [WA_W-1:0]         bus_word,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   input  logic [NBANK*32-1:0]     pad_in,
   output logic [NBANK*32-1:0]     pad_out,
   output logic [NBANK*32-1:0]     pad_oe,
   output logic                    irq
);
   generate
      if (NBANK < 1) begin : g_bad_nbank
         $error("banked_gpio: NBANK must be at least 1");
      end
      if (PINS_PER_BANK < 1 || PINS_PER_BANK > 32 ||
          LAST_BANK_PINS < 1 || LAST_BANK_PINS > 32) begin : g_bad_width
         $error("banked_gpio: bank widths must be within 1..32");
      end
   endgenerate

   logic [BSEL_W-1:0]    bank_idx;
   logic [REG_SEL_W-1:0] reg_sel;
   logic [31:0]          bank_rd [NBANK];
   logic [NBANK-1:0]     bank_pend;

   assign bank_idx = bus_word[WA_W-1:REG_SEL_W];
   assign reg_sel  = bus_word[REG_SEL_W-1:0];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam int PINS = (b == NBANK - 1) ? LAST_BANK_PINS : PINS_PER_BANK;
      logic sel_here;
      assign sel_here = bus_sel && bus_wr && (int'(bank_idx) == b);

      gpio_bank #(.PINS(PINS)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (sel_here),
         .reg_sel (reg_sel),
         .wdata   (bus_wdata),
         .rdata   (bank_rd[b]),
         .pad_in  (pad_in[b*32 +: 32]),
         .pad_out (pad_out[b*32 +: 32]),
         .pad_oe  (pad_oe[b*32 +: 32]),
         .pend_any(bank_pend[b])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (int'(bank_idx) == b) bus_rdata = bank_rd[b];
      end
   end

   assign irq = |bank_pend;

   // R2: the shared line is low during the first cycle out of reset
   assert_irq_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq);
endmodule

// File: tb/banked_gpio_test.sv
`timescale 1ns/1ps
module banked_gpio_test;
   localparam int NBANK = 2;
   localparam int WA_W  = 4;

   logic              clk = 0;
   logic              rst_n = 0;
   logic              bus_sel = 0, bus_wr = 0;
   logic [WA_W-1:0]   bus_word = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NBANK*32-1:0] pad_in = '0, pad_out, pad_oe;
   logic              irq;

   int n_checks = 0;
   int n_fail   = 0;

   banked_gpio uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   always #10 clk = ~clk;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_word = WA_W'(addr >> 2); bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input int addr, output logic [31:0] d);
      @(negedge clk);
      bus_word = WA_W'(addr >> 2);
      #1 d = bus_rdata;
   endtask

   task automatic rd_chk(input string tag, input int addr, input logic [31:0] exp);
      logic [31:0] v;
      rd(addr, v);
      check(tag, {32'h0, v}, {32'h0, exp});
   endtask

   task automatic set_pad(input int idx, input logic v);
      @(negedge clk);
      pad_in[idx] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic clear_all;
      wr(32'h1C, 32'hFFFF_FFFF);
      wr(32'h3C, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset;
      check("R2 pad_oe", pad_oe, 64'h0);
      check("R2 irq", {63'h0, irq}, 64'h0);
      rd_chk("R2 dir bank0", 32'h08, 32'hFFFF_FFFF);
      rd_chk("R2 dir bank1", 32'h28, 32'h000F_FFFF);
      rd_chk("R2 status bank0", 32'h1C, 32'h0);
      rd_chk("R2 enable bank1", 32'h34, 32'h0);
      rd_chk("R2 level bank0", 32'h18, 32'h0);
   endtask

   task automatic t_regs;
      wr(32'h14, 32'hA5A5_0F0F);
      rd_chk("R1 enable bank0 readback", 32'h14, 32'hA5A5_0F0F);
      wr(32'h2C, 32'hFFFF_FFFF);
      rd_chk("R1 R12 polarity bank1 limited", 32'h2C, 32'h000F_FFFF);
      rd_chk("R1 polarity bank0 untouched", 32'h0C, 32'h0);
      wr(32'h14, 32'h0);
      wr(32'h2C, 32'h0);
   endtask

   task automatic t_drive;
      logic [31:0] v;
      wr(32'h08, 32'hFFFF_FF00);
      wr(32'h04, 32'h0000_005A);
      check("R3 oe low byte", {56'h0, pad_oe[7:0]}, 64'hFF);
      check("R3 out low byte", {56'h0, pad_out[7:0]}, 64'h5A);
      check("R3 inputs not driven", {32'h0, pad_oe[31:8], 8'h0}, 64'h0);
      @(negedge clk);
      pad_in[31:0] = 32'hABCD_0000;
      rd(32'h04, v);
      check("R5 one edge after pad change", {32'h0, v}, 64'h0000_005A);
      rd(32'h04, v);
      check("R5 two edges after pad change", {32'h0, v}, 64'hABCD_005A);
      wr(32'h00, 32'h0000_0003);
      check("R4 open-drain oe", {56'h0, pad_oe[7:0]}, 64'hFD);
      check("R4 open-drain out", {56'h0, pad_out[7:0]}, 64'h58);
      wr(32'h00, 32'h0);
      wr(32'h04, 32'h0);
      wr(32'h08, 32'hFFFF_FFFF);
      @(negedge clk);
      pad_in[31:0] = '0;
      repeat (4) @(negedge clk);
      clear_all();
   endtask

   task automatic t_rising;
      wr(32'h0C, 32'h0000_0010);
      set_pad(4, 1);
      rd_chk("R6 rising sets", 32'h1C, 32'h10);
      wr(32'h1C, 32'h0);
      rd_chk("R10 write zero keeps", 32'h1C, 32'h10);
      wr(32'h1C, 32'h10);
      rd_chk("R10 write one clears", 32'h1C, 32'h0);
      set_pad(4, 0);
      rd_chk("R6 falling ignored", 32'h1C, 32'h0);
   endtask

   task automatic t_falling;
      set_pad(5, 1);
      rd_chk("R7 rising ignored", 32'h1C, 32'h0);
      set_pad(5, 0);
      rd_chk("R7 falling sets", 32'h1C, 32'h20);
      clear_all();
   endtask

   task automatic t_both;
      wr(32'h30, 32'h0000_0008);
      wr(32'h2C, 32'h0000_0008);
      set_pad(35, 1);
      rd_chk("R8 both rising", 32'h3C, 32'h8);
      wr(32'h3C, 32'h8);
      set_pad(35, 0);
      rd_chk("R8 both falling", 32'h3C, 32'h8);
      wr(32'h3C, 32'h8);
   endtask

   task automatic t_level;
      wr(32'h18, 32'h0000_0040);
      repeat (3) @(negedge clk);
      rd_chk("R9 high level idle", 32'h1C, 32'h0);
      set_pad(6, 1);
      rd_chk("R9 high level sets", 32'h1C, 32'h40);
      wr(32'h1C, 32'h40);
      rd_chk("R9 level held after clear", 32'h1C, 32'h40);
      set_pad(6, 0);
      wr(32'h1C, 32'h40);
      rd_chk("R9 clears once level gone", 32'h1C, 32'h0);
      set_pad(7, 1);
      wr(32'h0C, 32'h0000_0090);
      wr(32'h18, 32'h0000_00C0);
      repeat (2) @(negedge clk);
      rd_chk("R9 low level idle", 32'h1C, 32'h0);
      set_pad(7, 0);
      rd_chk("R9 low level sets", 32'h1C, 32'h80);
      set_pad(7, 1);
      wr(32'h1C, 32'h80);
      rd_chk("R9 low level cleared", 32'h1C, 32'h0);
      wr(32'h18, 32'h0);
   endtask

   task automatic t_irq;
      clear_all();
      wr(32'h34, 32'h8);
      check("R11 irq idle", {63'h0, irq}, 64'h0);
      set_pad(35, 1);
      check("R11 irq raised", {63'h0, irq}, 64'h1);
      wr(32'h34, 32'h0);
      check("R11 irq gated", {63'h0, irq}, 64'h0);
      rd_chk("R11 status visible", 32'h3C, 32'h8);
      wr(32'h34, 32'h8);
      check("R11 irq after enable", {63'h0, irq}, 64'h1);
      wr(32'h3C, 32'h8);
      check("R11 irq cleared", {63'h0, irq}, 64'h0);
      wr(32'h34, 32'h0);
      set_pad(35, 0);
      clear_all();
   endtask

   task automatic t_width;
      wr(32'h30, 32'hFFFF_FFFF);
      @(negedge clk);
      pad_in[63:52] = 12'hFFF;
      repeat (4) @(negedge clk);
      rd_chk("R12 no status above width", 32'h3C, 32'h0);
      rd_chk("R12 data reads zero above width", 32'h24, 32'h0);
      wr(32'h28, 32'h0);
      check("R12 oe limited to width", {32'h0, pad_oe[63:32]}, 64'h000F_FFFF);
      wr(32'h28, 32'hFFFF_FFFF);
      @(negedge clk);
      pad_in[63:52] = '0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_drive();
      t_rising();
      t_falling();
      t_both();
      t_level();
      t_irq();
      t_width();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule